// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt lines and drives two processor request outputs: a normal interrupt request (`irq_o`) and a fast interrupt request (`fiq_o`). A per-source select bit decides which output a source feeds. Software can mask each source, raise a source by itself, and read both raw and masked status. All of this is done through a small 32-bit register bus that has byte addresses and single-cycle read and write strobes.

Sixteen vectored slots give the normal interrupt path a priority order. Each slot names one source and holds a handler address, and slot 0 has the highest priority. When software reads the current-vector register, it gets the handler address of the winning slot, or a default address for sources that no slot serves. That read also puts the winning priority level in service. While a level is in service, requests at the same or a lower level are held off `irq_o`. Any write to the current-vector register retires the most recently entered level. Levels nest, so a higher-priority slot can still interrupt a handler that is running.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` and `fiq_o` are 0, and the enable, software, select and protect registers read 0. The test-control register at 0x300 always reads 0. All slots are disabled and no level is in service.
- R2: Writing a 1 to a bit of 0x10 enables that source, and writing a 1 to a bit of 0x14 disables it. Bits written as 0 leave the enable mask unchanged. Reading 0x10 returns the enable mask.
- R3: Writing a 1 to a bit of 0x18 raises a software request for that source, and writing a 1 to a bit of 0x1C withdraws it. Bits written as 0 have no effect. The software request is ORed with the input line. Reading 0x08 returns the OR of the input lines and software requests, before the enable mask is applied.
- R4: In the select register at 0x0C, a 1 routes the source to the fast path and a 0 routes it to the normal path. Reading 0x00 returns the enabled pending sources that are on the normal path. Reading 0x04 returns the enabled pending sources that are on the fast path.
- R5: `fiq_o` is registered. One clock after the inputs change, it is the OR of the enabled pending sources on the fast path. Priority levels in service never mask it.
- R6: Reading 0x30 returns the address stored at 0x100+4*i, where i is the lowest-numbered enabled slot whose source is pending on the normal path and not masked by the levels in service. If no such slot exists, the read returns the default address at 0x34.
- R7: `irq_o` is registered. It is 1 when a normal-path pending source is at a level above every level in service. A source served by slot i is at level i. A source that no enabled slot serves is at level 16, the lowest level. A read of 0x30 puts the winning level in service (level 16 when only unserved sources are pending; nothing when no source is pending). This masks that level and all lower levels from the next clock on.
- R8: Any write to 0x30 retires the most recently entered level, which is the highest-priority level in service. This unmasks the levels below it that are not themselves in service.
- R9: A slot control word at 0x200+4*i holds the source number in bits 4:0 and the slot enable in bit 5. A slot with bit 5 clear serves no source. Slot control words and slot addresses read back what was written.
- R10: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return one identification byte each in bits 7:0, lowest byte first. Bits 19:12 of the assembled word hold the vendor code.
- R11: Reading 0x20 returns the stored protect bit in bit 0. Reads of unmapped offsets, of 0x14 and of 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt lines |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
A corrupted enable, software or select bit shows up one clock later in the status reads at 0x00, 0x04 and 0x08 and on `fiq_o`. A bench model follows these registers through randomized write sequences and catches such a bit there. A wrong in-service state does not appear at once. It shows as `irq_o` held low while an active source is above every level in service, or as a wrong address from 0x30. The directed nesting sequence therefore checks `irq_o` one clock after every read and acknowledge of the vector.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int AW = 12;
  localparam int CTRL_EN_BIT = 5;

  localparam logic [AW-1:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [AW-1:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [AW-1:0] OFS_RAW_STAT = 12'h008;
  localparam logic [AW-1:0] OFS_ROUTE    = 12'h00C;
  localparam logic [AW-1:0] OFS_EN_SET   = 12'h010;
  localparam logic [AW-1:0] OFS_EN_CLR   = 12'h014;
  localparam logic [AW-1:0] OFS_SW_SET   = 12'h018;
  localparam logic [AW-1:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [AW-1:0] OFS_GUARD    = 12'h020;
  localparam logic [AW-1:0] OFS_VEC_CUR  = 12'h030;
  localparam logic [AW-1:0] OFS_VEC_DFLT = 12'h034;
  localparam logic [AW-1:0] OFS_TEST     = 12'h300;
  localparam logic [AW-1:0] OFS_ID0      = 12'hFE0;
  localparam logic [AW-1:0] OFS_ID1      = 12'hFE4;
  localparam logic [AW-1:0] OFS_ID2      = 12'hFE8;
  localparam logic [AW-1:0] OFS_ID3      = 12'hFEC;

  localparam logic [3:0] PAGE_VADDR = 4'h1;
  localparam logic [3:0] PAGE_VCTRL = 4'h2;
endpackage

// File: rtl/vic_ctlregs.sv
module vic_ctlregs
  import vic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] soft_q,
  output logic [NSRC-1:0] sel_q,
  output logic            guard_q,
  output logic [DW-1:0]   dflt_q
);
  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      soft_q  <= '0;
      sel_q   <= '0;
      guard_q <= 1'b0;
      dflt_q  <= '0;
    end else if (we) begin
      case (waddr)
        OFS_EN_SET:   en_q    <= en_q | wbits;
        OFS_EN_CLR:   en_q    <= en_q & ~wbits;
        OFS_SW_SET:   soft_q  <= soft_q | wbits;
        OFS_SW_CLR:   soft_q  <= soft_q & ~wbits;
        OFS_ROUTE:    sel_q   <= wbits;
        OFS_GUARD:    guard_q <= wdata[0];
        OFS_VEC_DFLT: dflt_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_slots.sv
module vic_slots
  import vic_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int SW    = 5,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [DW-1:0]               wdata,
  output logic [NSLOT-1:0][DW-1:0]    vaddr_q,
  output logic [NSLOT-1:0]            slot_en_q,
  output logic [NSLOT-1:0][SW-1:0]    slot_src_q
);
  logic in_word;
  assign in_word = (waddr[1:0] == 2'b00);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic hit_addr, hit_ctrl;
    assign hit_addr = we && in_word && (waddr[11:8] == PAGE_VADDR) &&
                      (waddr[7:2] == 6'(i));
    assign hit_ctrl = we && in_word && (waddr[11:8] == PAGE_VCTRL) &&
                      (waddr[7:2] == 6'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vaddr_q[i]    <= '0;
        slot_en_q[i]  <= 1'b0;
        slot_src_q[i] <= '0;
      end else begin
        if (hit_addr) vaddr_q[i] <= wdata;
        if (hit_ctrl) begin
          slot_en_q[i]  <= wdata[CTRL_EN_BIT];
          slot_src_q[i] <= wdata[SW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int SW    = 5,
  parameter int IW    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSLOT-1:0]         slot_en,
  input  logic [NSLOT-1:0][SW-1:0] slot_src,
  input  logic [NSRC-1:0]          cand,
  input  logic                     enter,
  input  logic                     retire,
  output logic                     win_vld,
  output logic [IW-1:0]            win_idx,
  output logic                     irq_next,
  output logic [NSLOT:0]           in_svc
);
  // One bit per level; nesting is strictly by priority, so the newest
  // entry is always the lowest set bit.
  logic [NSLOT:0]   svc_q;
  logic [NSLOT:0]   allow;
  logic [NSRC-1:0]  vect_mask;
  logic [NSLOT-1:0] slot_hit;
  logic             dflt_hit;

  always_comb begin
    allow[0] = ~svc_q[0];
    for (int l = 1; l <= NSLOT; l++) allow[l] = allow[l-1] & ~svc_q[l];
  end

  always_comb begin
    vect_mask = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_en[i]) vect_mask[slot_src[i]] = 1'b1;
      slot_hit[i] = slot_en[i] & cand[slot_src[i]] & allow[i];
    end
  end

  assign dflt_hit = (|(cand & ~vect_mask)) & allow[NSLOT];

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign irq_next = (|slot_hit) | dflt_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= '0;
    end else if (retire) begin
      svc_q <= svc_q & (svc_q - 1'b1);
    end else if (enter) begin
      if (win_vld)       svc_q[win_idx] <= 1'b1;
      else if (dflt_hit) svc_q[NSLOT]   <= 1'b1;
    end
  end

  assign in_svc = svc_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NSRC     = 32,
  parameter int          NSLOT    = 16,
  parameter int          DW       = 32,
  parameter logic [31:0] PERIPH_ID = 32'h0015_7A31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int SW = $clog2(NSRC);
  localparam int IW = $clog2(NSLOT);

  logic [NSRC-1:0]            en_q, soft_q, sel_q;
  logic                       guard_q;
  logic [DW-1:0]              dflt_q;
  logic [NSLOT-1:0][DW-1:0]   vaddr_q;
  logic [NSLOT-1:0]           slot_en_q;
  logic [NSLOT-1:0][SW-1:0]   slot_src_q;
  logic [NSRC-1:0]            raw, pend, cand, fast;
  logic                       win_vld, irq_next;
  logic [IW-1:0]              win_idx;
  logic [NSLOT:0]             in_svc;
  logic                       vec_rd, vec_wr;
  logic [DW-1:0]              rd_val, cur_vec;
  logic [IW-1:0]              ridx;
  logic                       ridx_ok;

  vic_ctlregs #(.NSRC(NSRC), .DW(DW)) i_ctl (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(addr), .wdata(wdata),
    .en_q(en_q), .soft_q(soft_q), .sel_q(sel_q), .guard_q(guard_q),
    .dflt_q(dflt_q)
  );

  vic_slots #(.NSLOT(NSLOT), .SW(SW), .DW(DW)) i_slots (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(addr), .wdata(wdata),
    .vaddr_q(vaddr_q), .slot_en_q(slot_en_q), .slot_src_q(slot_src_q)
  );

  assign raw  = src_i | soft_q;
  assign pend = raw & en_q;
  assign cand = pend & ~sel_q;
  assign fast = pend & sel_q;

  assign vec_rd = rd_en && (addr == OFS_VEC_CUR);
  assign vec_wr = wr_en && (addr == OFS_VEC_CUR);

  vic_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .IW(IW)) i_prio (
    .clk(clk), .rst(rst), .slot_en(slot_en_q), .slot_src(slot_src_q),
    .cand(cand), .enter(vec_rd), .retire(vec_wr),
    .win_vld(win_vld), .win_idx(win_idx), .irq_next(irq_next),
    .in_svc(in_svc)
  );

  assign cur_vec = win_vld ? vaddr_q[win_idx] : dflt_q;
  assign ridx    = addr[2 +: IW];
  assign ridx_ok = (addr[1:0] == 2'b00) && (int'(addr[7:2]) < NSLOT);

  always_comb begin
    rd_val = '0;
    case (addr)
      OFS_IRQ_STAT: rd_val[NSRC-1:0] = cand;
      OFS_FIQ_STAT: rd_val[NSRC-1:0] = fast;
      OFS_RAW_STAT: rd_val[NSRC-1:0] = raw;
      OFS_ROUTE:    rd_val[NSRC-1:0] = sel_q;
      OFS_EN_SET:   rd_val[NSRC-1:0] = en_q;
      OFS_SW_SET:   rd_val[NSRC-1:0] = soft_q;
      OFS_GUARD:    rd_val[0]        = guard_q;
      OFS_VEC_CUR:  rd_val           = cur_vec;
      OFS_VEC_DFLT: rd_val           = dflt_q;
      OFS_TEST:     rd_val           = '0;
      OFS_ID0:      rd_val[7:0]      = PERIPH_ID[7:0];
      OFS_ID1:      rd_val[7:0]      = PERIPH_ID[15:8];
      OFS_ID2:      rd_val[7:0]      = PERIPH_ID[23:16];
      OFS_ID3:      rd_val[7:0]      = PERIPH_ID[31:24];
      default: begin
        if (ridx_ok && addr[11:8] == PAGE_VADDR) begin
          rd_val = vaddr_q[ridx];
        end else if (ridx_ok && addr[11:8] == PAGE_VCTRL) begin
          rd_val[CTRL_EN_BIT] = slot_en_q[ridx];
          rd_val[SW-1:0]      = slot_src_q[ridx];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq_o <= irq_next;
      fiq_o <= |fast;
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic            wr_en,
  input logic            rd_en,
  input logic [11:0]     addr,
  input logic [31:0]     wdata,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] soft_q,
  input logic [NSRC-1:0] sel_q,
  input logic [NSLOT:0]  in_svc
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o));

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 12'h010) |=>
      ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

  p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 12'h014) |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));

  p_fiq_track_r5: assert property (@(posedge clk) disable iff (rst)
    (|((src_i | soft_q) & en_q & sel_q)) |=> fiq_o);

  p_idle_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (in_svc == '0 && (|((src_i | soft_q) & en_q & ~sel_q))) |=> irq_o);

  p_retire_one_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr == 12'h030 && in_svc != '0) |=>
      ($countones(in_svc) + 1 == $past($countones(in_svc))));
endmodule

bind vec_irq_ctrl vic_chk #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .en_q(en_q), .soft_q(soft_q), .sel_q(sel_q), .in_svc(in_svc)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m_en = '0, m_soft = '0, m_sel = '0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] f_pend();
    return (src_i | m_soft) & m_en;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, id;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R1 fiq_o", {31'b0, fiq_o}, 0);
    rd(12'h010, d); check("R1 enable", d, 0);
    rd(12'h00C, d); check("R1 select", d, 0);
    rd(12'h300, d); check("R1 test ctrl", d, 0);
    rd(12'h220, d); check("R1 slot ctrl", d, 0);

    // random phase: no slots enabled, nothing in service
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a, b;
      src_i = $urandom;
      a = $urandom; b = $urandom & $urandom;
      wr(12'h010, a); m_en = m_en | a;
      wr(12'h014, b); m_en = m_en & ~b;
      a = $urandom & $urandom; b = $urandom;
      wr(12'h018, a); m_soft = m_soft | a;
      wr(12'h01C, b); m_soft = m_soft & ~b;
      if (n % 4 == 0) begin a = $urandom; wr(12'h00C, a); m_sel = a; end
      if (n % 7 == 3) src_i = '0;
      rd(12'h010, d); check("R2 enable mask", d, m_en);
      rd(12'h018, d); check("R3 soft mask", d, m_soft);
      rd(12'h008, d); check("R3 raw status", d, src_i | m_soft);
      rd(12'h000, d); check("R4 irq status", d, f_pend() & ~m_sel);
      rd(12'h004, d); check("R4 fiq status", d, f_pend() & m_sel);
      check("R5 fiq_o", {31'b0, fiq_o}, {31'b0, |(f_pend() & m_sel)});
      check("R7 irq_o idle", {31'b0, irq_o}, {31'b0, |(f_pend() & ~m_sel)});
    end

    // directed: clear everything
    wr(12'h014, 32'hFFFF_FFFF); m_en = '0;
    wr(12'h01C, 32'hFFFF_FFFF); m_soft = '0;
    wr(12'h00C, 32'h0); m_sel = '0;
    set_src('0);

    // slot 2 serves source 7, slot 9 serves source 3; 20 is unserved
    wr(12'h108, 32'h1000_0200);
    wr(12'h208, 32'h0000_0027);
    wr(12'h124, 32'h0000_9900);
    wr(12'h224, 32'h0000_0023);
    wr(12'h034, 32'h0000_DEF0);
    wr(12'h010, (32'h1 << 7) | (32'h1 << 3) | (32'h1 << 20));
    rd(12'h208, d); check("R9 ctrl readback", d, 32'h27);
    rd(12'h108, d); check("R9 vaddr readback", d, 32'h1000_0200);

    set_src(32'h1 << 3);
    check("R7 irq raised", {31'b0, irq_o}, 1);
    rd(12'h030, d); check("R6 slot 9 vector", d, 32'h9900);
    idle();
    check("R7 level 9 masks own source", {31'b0, irq_o}, 0);
    set_src((32'h1 << 3) | (32'h1 << 20));
    check("R7 lower level stays masked", {31'b0, irq_o}, 0);
    set_src((32'h1 << 3) | (32'h1 << 20) | (32'h1 << 7));
    check("R7 higher level preempts", {31'b0, irq_o}, 1);
    rd(12'h030, d); check("R6 slot 2 vector", d, 32'h1000_0200);
    set_src((32'h1 << 3) | (32'h1 << 20));
    wr(12'h030, 32'h0); idle();
    check("R8 retire level 2, level 9 still masks", {31'b0, irq_o}, 0);
    wr(12'h030, 32'h0); idle();
    check("R8 retire level 9 unmasks", {31'b0, irq_o}, 1);
    rd(12'h030, d); check("R6 slot 9 again", d, 32'h9900);
    wr(12'h030, 32'h0);
    set_src(32'h1 << 20);
    rd(12'h030, d); check("R6 unserved source gets default", d, 32'hDEF0);
    idle();
    check("R7 level 16 in service", {31'b0, irq_o}, 0);
    wr(12'h030, 32'h0);
    set_src('0);
    rd(12'h030, d); check("R6 nothing pending gives default", d, 32'hDEF0);
    idle();
    check("R7 no spurious irq", {31'b0, irq_o}, 0);

    // R9 disabled slot serves nothing
    wr(12'h224, 32'h0000_0003);
    rd(12'h224, d); check("R9 ctrl disabled readback", d, 32'h3);
    set_src(32'h1 << 3);
    rd(12'h030, d); check("R9 disabled slot falls to default", d, 32'hDEF0);
    wr(12'h030, 32'h0);

    // R4/R5 fast path
    wr(12'h00C, 32'h1 << 7); m_sel = 32'h1 << 7;
    set_src((32'h1 << 7) | (32'h1 << 3));
    check("R5 fiq_o set", {31'b0, fiq_o}, 1);
    rd(12'h004, d); check("R4 fiq status", d, 32'h1 << 7);
    rd(12'h030, d); check("R4 fast source not vectored", d, 32'hDEF0);
    idle();
    check("R5 fiq unmasked by priority", {31'b0, fiq_o}, 1);
    wr(12'h030, 32'h0);

    // R10 identification bytes
    id = '0;
    for (int k = 0; k < 4; k++) begin
      rd(12'hFE0 + 12'(4 * k), d);
      check("R10 id byte upper bits", d & 32'hFFFF_FF00, 0);
      id = id | ({24'b0, d[7:0]} << (8 * k));
    end
    check("R10 vendor code", {24'b0, id[19:12]}, 32'h57);

    // R11 protect and unmapped
    wr(12'h020, 32'h1);
    rd(12'h020, d); check("R11 protect bit", d, 1);
    rd(12'h040, d); check("R11 unmapped", d, 0);
    rd(12'h014, d); check("R11 enable clear reads zero", d, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule